// File: doc/BRIEF.md
# Three-Key Password Lock Controller

This block is a Moore state machine that watches a two-key keypad (keys A and B) and opens a lock when the code B, A, B is entered. Each key event arrives as a synchronous 3-bit code `{strobe, a, b}` that is valid for one clock cycle. Debouncing and edge detection are done upstream.

The block drives two outputs. The first is a 4-bit count of the keys entered in the current attempt, meant for a digit display. The second is an unlock pulse that lasts exactly one cycle. A wrong key does not end the attempt at once. The machine always takes three keys before it goes back to idle, so the length of an attempt never shows where the mistake was. The one exception is a wrong key in the last position, which returns to idle straight away. All outputs come only from the state register.

Top module: `keypad_lock`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the machine goes to idle. After that edge `digit_count` is 0 and `unlock` is 0.
- R2: The key codes are as follows. `key_code` = 3'b101 is key B and 3'b110 is key A. The keys B, A, B in that order raise `digit_count` to 1, 2 and 3. `unlock` is 1 in the cycle in which the count reads 3.
- R3: A code with bit 2 = 0 is "no key". It leaves `digit_count` unchanged in every state except the unlock state.
- R4: `unlock` is high for exactly one cycle. In the next cycle `digit_count` is 0, whatever the input.
- R5: A first key other than B sets the count to 1. Any second key then gives a count of 2, and any third key gives 0. `unlock` stays low throughout.
- R6: After a correct first key, a second key other than A sets the count to 2. Any further key then returns the count to 0 with no unlock.
- R7: After a correct B, A, a third key other than B returns the count to 0 at once, with no unlock.
- R8: A code with bit 2 = 1 that is neither 3'b101 nor 3'b110 counts as a wrong key. A code with bit 2 = 0 is no key, whatever its low bits.
- R9: `digit_count` never exceeds 3, so its upper two bits are always 0. `unlock` is high only when the count is 3.
- R10: A key that arrives in the unlock cycle is dropped. The next attempt starts from the key after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_code | input | 3 | Key event {strobe, a, b}, one cycle per press |
| digit_count | output | 4 | Number of keys entered in the current attempt |
| unlock | output | 1 | One-cycle open pulse |

## Verification
The assertions check on every cycle the following properties:
- the count always moves one step per key,
- the count never exceeds three,
- unlock appears only with a count of 3 and only after the final B,
- unlock always falls to a count of 0 in the next cycle,
- reset always returns the machine to idle.

Some behaviours only the directed scenarios can show:
- the full counting path of each wrong-key position,
- the no-key gaps inside an attempt,
- the odd strobe codes that count as wrong keys,
- the key that is dropped in the unlock cycle before a second, correct attempt.

// File: rtl/lock_pkg.sv
// Package: shared types for the keypad lock.
// Assumes: the state codes below are fixed; the display count depends on them.
package lock_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'b000,
        ST_OK1  = 3'b001,
        ST_OK2  = 3'b010,
        ST_OPEN = 3'b011,
        ST_BAD1 = 3'b100,
        ST_BAD2 = 3'b101
    } lock_state_t;

    typedef enum logic [1:0] {
        KEY_NONE  = 2'd0,
        KEY_A     = 2'd1,
        KEY_B     = 2'd2,
        KEY_OTHER = 2'd3
    } key_class_t;

    localparam logic [2:0] CODE_A = 3'b110;
    localparam logic [2:0] CODE_B = 3'b101;
endpackage

// File: rtl/lock_key_decode.sv
// Module: sorts a raw key code into no key, A, B or another (wrong) key.
// Assumes: bit 2 of the code is the key strobe and each press lasts one cycle.
module lock_key_decode
    import lock_pkg::*;
(
    input  logic [2:0] code,
    output key_class_t kclass
);
    // Sort the code by its strobe and its exact value.
    always_comb begin
        if (!code[2])             kclass = KEY_NONE;
        else if (code == CODE_A)  kclass = KEY_A;
        else if (code == CODE_B)  kclass = KEY_B;
        else                      kclass = KEY_OTHER;
    end
endmodule

// File: rtl/lock_next_state.sv
// Module: next-state function of the password machine.
// Assumes: wrong keys still count towards three; the unlock state always leaves.
module lock_next_state
    import lock_pkg::*;
(
    input  lock_state_t cur,
    input  key_class_t  kclass,
    output lock_state_t nxt
);
    logic pressed;
    assign pressed = (kclass != KEY_NONE);

    // Choose the successor state from the current state and the key class.
    always_comb begin
        nxt = cur;
        case (cur)
            ST_IDLE: if (pressed) nxt = (kclass == KEY_B) ? ST_OK1 : ST_BAD1;
            ST_OK1:  if (pressed) nxt = (kclass == KEY_A) ? ST_OK2 : ST_BAD2;
            ST_OK2:  if (pressed) nxt = (kclass == KEY_B) ? ST_OPEN : ST_IDLE;
            ST_OPEN: nxt = ST_IDLE;
            ST_BAD1: if (pressed) nxt = ST_BAD2;
            ST_BAD2: if (pressed) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/lock_out_decode.sv
// Module: Moore output decode, giving the key count and the unlock pulse.
// Assumes: the outputs depend on the state alone; unused codes show an idle display.
module lock_out_decode
    import lock_pkg::*;
#(
    parameter int DISP_W = 4
) (
    input  lock_state_t       cur,
    output logic [DISP_W-1:0] count,
    output logic              open
);
    localparam int CNT_W = 2;

    logic [CNT_W-1:0] small_cnt;

    // Map each state to the number of keys entered so far.
    always_comb begin
        case (cur)
            ST_OK1, ST_BAD1: small_cnt = 2'd1;
            ST_OK2, ST_BAD2: small_cnt = 2'd2;
            ST_OPEN:         small_cnt = 2'd3;
            default:         small_cnt = 2'd0;
        endcase
    end

    generate
        if (DISP_W > CNT_W) begin : g_pad
            assign count = {{(DISP_W-CNT_W){1'b0}}, small_cnt};
        end else begin : g_trim
            assign count = small_cnt[DISP_W-1:0];
        end
    endgenerate

    assign open = (cur == ST_OPEN);
endmodule

// File: rtl/keypad_lock.sv
// Module: top of the three-key password lock (code B, A, B).
// Assumes: synchronous active-low reset; key events are synchronous single-cycle codes.
module keypad_lock
    import lock_pkg::*;
#(
    parameter int DISP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        key_code,
    output logic [DISP_W-1:0] digit_count,
    output logic              unlock
);
    lock_state_t state_q;
    lock_state_t state_d;
    key_class_t  kclass;

    lock_key_decode u_dec (
        .code   (key_code),
        .kclass (kclass)
    );

    lock_next_state u_ns (
        .cur    (state_q),
        .kclass (kclass),
        .nxt    (state_d)
    );

    // State register, with reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    lock_out_decode #(.DISP_W(DISP_W)) u_out (
        .cur   (state_q),
        .count (digit_count),
        .open  (unlock)
    );
endmodule

// File: rtl/keypad_lock_chk.sv
// Module: protocol checker for keypad_lock, attached through bind.
// Assumes: it observes only the top-level ports.
module keypad_lock_chk #(
    parameter int DISP_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        key_code,
    input logic [DISP_W-1:0] digit_count,
    input logic              unlock
);
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (digit_count == 0 && !unlock));

    p_open_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
        unlock |-> ($past(digit_count) == 2 && $past(key_code) == 3'b101));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_code[2] && !unlock) |=> $stable(digit_count));

    p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        unlock |=> (!unlock && digit_count == 0));

    p_first_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_count == 0 && key_code[2]) |=> digit_count == 1);

    p_second_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_count == 1 && key_code[2]) |=> digit_count == 2);

    p_third_wrong_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_count == 2 && key_code[2] && key_code != 3'b101) |=> (digit_count == 0 && !unlock));

    p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_count <= 3) && (!unlock || digit_count == 3));
endmodule

bind keypad_lock keypad_lock_chk #(.DISP_W(DISP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_code    (key_code),
    .digit_count (digit_count),
    .unlock      (unlock)
);

// File: tb/tb_keypad_lock.sv
// Bench: directed scenarios for keypad_lock, one task per scenario.
module tb_keypad_lock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] key_code = 3'b000;
    logic [3:0] digit_count;
    logic       unlock;
    int         n_checks = 0;
    int         n_errors = 0;

    localparam logic [2:0] KA = 3'b110;
    localparam logic [2:0] KB = 3'b101;
    localparam logic [2:0] KN = 3'b000;

    always #4 clk = ~clk;

    keypad_lock dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_code    (key_code),
        .digit_count (digit_count),
        .unlock      (unlock)
    );

    // Compare both outputs against the expected values and count the check.
    task automatic expect_out(input string req, input int cnt, input logic op);
        n_checks++;
        if (digit_count !== cnt[3:0] || unlock !== op) begin
            n_errors++;
            $display("FAIL %s: count=%0d unlock=%b expected count=%0d unlock=%b",
                     req, digit_count, unlock, cnt, op);
        end
    endtask

    // Drive one key for a single cycle; called at a falling edge, returns at one.
    task automatic press(input logic [2:0] code);
        key_code = code;
        @(negedge clk);
        key_code = KN;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        gap(3);
        expect_out("R1 reset", 0, 1'b0);
        rst_n = 1'b1;
        gap(1);
    endtask

    task automatic t_correct_with_gaps();
        press(KB);  expect_out("R2 first B", 1, 1'b0);
        gap(3);     expect_out("R3 hold in first state", 1, 1'b0);
        press(3'b011); expect_out("R8 strobe low with bits set is no key", 1, 1'b0);
        press(KA);  expect_out("R2 then A", 2, 1'b0);
        gap(2);     expect_out("R3 hold in second state", 2, 1'b0);
        press(KB);  expect_out("R2 unlock", 3, 1'b1);
        gap(1);     expect_out("R4 pulse ends", 0, 1'b0);
        gap(2);     expect_out("R3 idle hold", 0, 1'b0);
    endtask

    task automatic t_wrong_first();
        press(KA);  expect_out("R5 wrong first", 1, 1'b0);
        press(KB);  expect_out("R5 second key", 2, 1'b0);
        press(KA);  expect_out("R5 third key to idle", 0, 1'b0);
    endtask

    task automatic t_wrong_second();
        press(KB);  expect_out("R6 good first", 1, 1'b0);
        press(KB);  expect_out("R6 wrong second", 2, 1'b0);
        gap(2);     expect_out("R3 hold after wrong", 2, 1'b0);
        press(KB);  expect_out("R6 third key to idle", 0, 1'b0);
    endtask

    task automatic t_wrong_third();
        press(KB); press(KA);
        expect_out("R7 two good", 2, 1'b0);
        press(KA);  expect_out("R7 wrong third to idle", 0, 1'b0);
    endtask

    task automatic t_odd_codes();
        press(3'b100); expect_out("R8 odd strobe code wrong first", 1, 1'b0);
        press(3'b111); expect_out("R8 odd strobe code counts", 2, 1'b0);
        press(KB);     expect_out("R8 attempt ends", 0, 1'b0);
    endtask

    task automatic t_back_to_back();
        press(KB); press(KA); press(KB);
        expect_out("R2 first attempt unlock", 3, 1'b1);
        press(KB);  expect_out("R10 key in unlock cycle dropped", 0, 1'b0);
        press(KB);  expect_out("R10 new attempt B", 1, 1'b0);
        press(KA);  expect_out("R10 new attempt A", 2, 1'b0);
        press(KB);  expect_out("R10 second unlock", 3, 1'b1);
        expect_out("R9 count within range", 3, 1'b1);
        gap(1);     expect_out("R4 second pulse ends", 0, 1'b0);
    endtask

    task automatic t_reset_mid();
        press(KB); press(KA);
        rst_n = 1'b0;
        gap(1);
        expect_out("R1 reset mid attempt", 0, 1'b0);
        rst_n = 1'b1;
        press(KB);  expect_out("R1 fresh start after reset", 1, 1'b0);
        press(KA); press(KA);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_correct_with_gaps();
        t_wrong_first();
        t_wrong_second();
        t_wrong_third();
        t_odd_codes();
        t_back_to_back();
        t_reset_mid();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule